// File: doc/BRIEF.md
# Dual-Clock FIFO with Post-Reset Access Guard

This block moves data words from a producer clocked by `wr_clk` to a consumer clocked by `rd_clk`. The two clocks share no phase or frequency relation. Each side keeps a binary pointer plus a Gray-coded copy of it. The Gray copy crosses into the other domain through a chain of flops. Each side computes its own fill level from its local pointer and the synchronized remote one. Storage is a plain inferred two-port array, written on `wr_clk` and read on `rd_clk`.

A single active-low asynchronous reset clears both sides at once. When it is released, each side first passes the release through its own two-flop reset synchronizer. It then holds a busy flag for a fixed number of its own clock edges. While a side is busy, its full or empty flag is forced high, and every access on that side is silently dropped. This keeps the memory and pointers safe while the reset settles.

On the write side, `wr_full` acts as the inverted ready: a push is taken on a `wr_clk` edge only if `wr_push` is high and `wr_full` is low at that edge. On the read side, `rd_empty` acts as the inverted valid: a pop is taken only if `rd_pop` is high and `rd_empty` is low. The popped word is then presented with a one-cycle `rd_dvalid` strobe. This happens one or two `rd_clk` edges later, depending on the build-time read latency. There is no back-pressure on the output: the consumer must capture the word on the cycle `rd_dvalid` is high.

Top module: `xfifo_dc`

## Requirements
- R1: While `arst_n` is low, `wr_busy` is high. It stays high until the (BUSY_CYC+2)-th `wr_clk` rising edge after `arst_n` rises (22 edges at the default BUSY_CYC=20), and then stays low until the next reset. `wr_full` is high whenever `wr_busy` is high.
- R2: `rd_busy` follows the same rule counted in `rd_clk` edges. `rd_empty` is high whenever `rd_busy` is high. Pops issued while `rd_busy` is high produce no `rd_dvalid` and leave `rd_level` at 0.
- R3: A word is stored only on a `wr_clk` edge where `wr_push` is high and `wr_full` is low. Pushes while busy or full leave `wr_level` unchanged and do not alter stored data.
- R4: `wr_level` shows the new count right after the `wr_clk` edge that accepts a push. With the read side idle, one push reads 1 and two pushes read 2.
- R5: `wr_full` is high exactly when 2^AW words are held (16 at the default AW=4). It is low when 2^AW-1 words are held.
- R6: After a push lands on an empty FIFO, `rd_empty` falls and `rd_level` becomes 1 on the SYNC_STAGES-th `rd_clk` rising edge after the write edge (3 at default), and not before.
- R7: With RD_LAT=RD_LAT1, `rd_dvalid` is high and `rd_data` holds the word on the cycle after the `rd_clk` edge that accepts a pop. With RD_LAT=RD_LAT2, this happens one cycle later. In both cases `rd_dvalid` lasts one cycle per pop.
- R8: Words leave in the order they were accepted.
- R9: After two pushes followed by one pop, both `wr_level` and `rd_level` settle to 1.
- R10: A pop while `rd_empty` is high gives no `rd_dvalid`, leaves `rd_level` at 0, and does not disturb the next word pushed.
- R11: Driving `arst_n` low at any time raises `wr_busy`, `rd_busy`, `wr_full` and `rd_empty` and zeroes both levels without waiting for a clock. Contents pushed before the reset are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| arst_n | input | 1 | Asynchronous reset for both domains, active low |
| wr_clk | input | 1 | Producer clock |
| wr_push | input | 1 | Request to store `wr_data` |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | No push can be accepted (full or busy) |
| wr_busy | output | 1 | Write side still in its post-reset guard window |
| wr_level | output | AW+1 | Words held, as seen from the write side |
| rd_clk | input | 1 | Consumer clock |
| rd_pop | input | 1 | Request to remove the oldest word |
| rd_data | output | DW | Popped word, meaningful while `rd_dvalid` is high |
| rd_dvalid | output | 1 | One-cycle strobe marking `rd_data` valid |
| rd_empty | output | 1 | No pop can be accepted (empty or busy) |
| rd_busy | output | 1 | Read side still in its post-reset guard window |
| rd_level | output | AW+1 | Words held, as seen from the read side |

## Verification
Write-side results are due right after the `wr_clk` edge that takes the push. The bench drives on the falling edge and samples on the next falling edge. Busy release is counted edge by edge, sampling 1 ns after each rising edge, to hit exactly BUSY_CYC+2. The cross-domain effects are checked the same way: the fall of `rd_empty` is counted in `rd_clk` edges from the write edge and must land on edge SYNC_STAGES. Level settling after a pop is only checked after eight edges of the far clock. Two instances with latency one and two share the stimulus, so each pop is sampled one and two `rd_clk` falling edges after its accepting edge.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;
  // number of rd_clk edges between an accepted pop and its data strobe
  typedef enum int unsigned {
    RD_LAT1 = 1,
    RD_LAT2 = 2
  } rd_lat_e;
endpackage

// File: rtl/xfifo_rst_guard.sv
`timescale 1ns/1ps
module xfifo_rst_guard #(
  parameter int unsigned BUSY_CYC = 20
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(BUSY_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (!sync_q[1]) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == CW'(BUSY_CYC - 1)) busy_q <= 1'b0;
      else                            cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;

  // R1 / R2: once released, the guard does not come back without a reset
  a_r1_busy_stays_low: assert property (@(posedge clk) disable iff (!rst_n_o)
    !busy_q |=> !busy_q);
endmodule

// File: rtl/xfifo_sync.sv
`timescale 1ns/1ps
module xfifo_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xfifo_wr_ctrl.sv
`timescale 1ns/1ps
module xfifo_wr_ctrl #(
  parameter int unsigned AW = 4,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          push,
  input  logic [PW-1:0] rgray_s,
  output logic          wen,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full,
  output logic [PW-1:0] level
);
  localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

  logic [PW-1:0] bin_q, gray_q, bin_nx, rbin_s;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign full   = busy || (gray_q == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
  assign wen    = push && !full;
  assign bin_nx = bin_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (wen) begin
      bin_q  <= bin_nx;
      gray_q <= bin_nx ^ (bin_nx >> 1);
    end
  end

  assign waddr = bin_q[AW-1:0];
  assign wgray = gray_q;
  assign level = bin_q - rbin_s;

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(bin_q));
  a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH);
endmodule

// File: rtl/xfifo_rd_ctrl.sv
`timescale 1ns/1ps
module xfifo_rd_ctrl #(
  parameter int unsigned AW = 4,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          pop,
  input  logic [PW-1:0] wgray_s,
  output logic          ren,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          empty,
  output logic [PW-1:0] level
);
  localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

  logic [PW-1:0] bin_q, gray_q, bin_nx, wbin_s;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign empty  = busy || (gray_q == wgray_s);
  assign ren    = pop && !empty;
  assign bin_nx = bin_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (ren) begin
      bin_q  <= bin_nx;
      gray_q <= bin_nx ^ (bin_nx >> 1);
    end
  end

  assign raddr = bin_q[AW-1:0];
  assign rgray = gray_q;
  assign level = wbin_s - bin_q;

  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> $stable(bin_q));
  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH);
endmodule

// File: rtl/xfifo_ram.sv
`timescale 1ns/1ps
module xfifo_ram #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          wclk,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          ren,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (wen) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (ren) rdata <= mem[raddr];
  end
endmodule

// File: rtl/xfifo_dc.sv
`timescale 1ns/1ps
module xfifo_dc #(
  parameter int unsigned       DW          = 8,
  parameter int unsigned       AW          = 4,
  parameter int unsigned       BUSY_CYC    = 20,
  parameter int unsigned       SYNC_STAGES = 3,
  parameter xfifo_pkg::rd_lat_e RD_LAT     = xfifo_pkg::RD_LAT1,
  localparam int unsigned      PW          = AW + 1
) (
  input  logic          arst_n,
  input  logic          wr_clk,
  input  logic          wr_push,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  output logic          wr_busy,
  output logic [PW-1:0] wr_level,
  input  logic          rd_clk,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  output logic          rd_dvalid,
  output logic          rd_empty,
  output logic          rd_busy,
  output logic [PW-1:0] rd_level
);
  logic          wrst_n, rrst_n;
  logic          wen, ren;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [DW-1:0] mem_q;
  logic          v1_q;

  xfifo_rst_guard #(.BUSY_CYC(BUSY_CYC)) u_wguard (
    .clk(wr_clk), .arst_n(arst_n), .rst_n_o(wrst_n), .busy_o(wr_busy));
  xfifo_rst_guard #(.BUSY_CYC(BUSY_CYC)) u_rguard (
    .clk(rd_clk), .arst_n(arst_n), .rst_n_o(rrst_n), .busy_o(rd_busy));

  xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  xfifo_wr_ctrl #(.AW(AW)) u_wctl (
    .clk(wr_clk), .rst_n(wrst_n), .busy(wr_busy), .push(wr_push),
    .rgray_s(rgray_s), .wen(wen), .waddr(waddr), .wgray(wgray),
    .full(wr_full), .level(wr_level));
  xfifo_rd_ctrl #(.AW(AW)) u_rctl (
    .clk(rd_clk), .rst_n(rrst_n), .busy(rd_busy), .pop(rd_pop),
    .wgray_s(wgray_s), .ren(ren), .raddr(raddr), .rgray(rgray),
    .empty(rd_empty), .level(rd_level));

  xfifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wr_clk), .wen(wen), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .ren(ren), .raddr(raddr), .rdata(mem_q));

  always_ff @(posedge rd_clk or negedge rrst_n) begin
    if (!rrst_n) v1_q <= 1'b0;
    else         v1_q <= ren;
  end

  generate
    if (RD_LAT == xfifo_pkg::RD_LAT2) begin : g_lat2
      logic [DW-1:0] d2_q;
      logic          v2_q;
      always_ff @(posedge rd_clk) begin
        if (v1_q) d2_q <= mem_q;
      end
      always_ff @(posedge rd_clk or negedge rrst_n) begin
        if (!rrst_n) v2_q <= 1'b0;
        else         v2_q <= v1_q;
      end
      assign rd_data   = d2_q;
      assign rd_dvalid = v2_q;

      a_r7_strobe_two: assert property (@(posedge rd_clk) disable iff (!rrst_n)
        (rd_pop && !rd_empty) |=> ##1 rd_dvalid);
    end else begin : g_lat1
      assign rd_data   = mem_q;
      assign rd_dvalid = v1_q;

      a_r7_strobe_one: assert property (@(posedge rd_clk) disable iff (!rrst_n)
        (rd_pop && !rd_empty) |=> rd_dvalid);
    end
  endgenerate

  // R2: a busy read side never produces a data strobe
  a_r2_quiet_busy: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    (rd_busy && $past(rd_busy) && $past(rd_busy, 2)) |-> !rd_dvalid);
  // R1: a busy write side reports full
  a_r1_full_busy: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    wr_busy |-> wr_full);
endmodule

// File: tb/xfifo_dc_tb_top.sv
`timescale 1ns/1ps
module xfifo_dc_tb_top;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 4;
  localparam int unsigned PW = AW + 1;
  localparam int unsigned BUSY_CYC = 20;
  localparam int unsigned SYNC_STAGES = 3;
  localparam int unsigned DEPTH = 1 << AW;

  // {push data, expected wr_level right after the accepting edge}
  localparam logic [15:0] VEC [8] = '{
    16'h1101, 16'h2202, 16'h3303, 16'h4404,
    16'h5505, 16'h6606, 16'h7707, 16'h8808
  };

  logic          arst_n = 1'b0;
  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          wr_push = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_pop = 1'b0;

  logic          wr_full, wr_busy, rd_dvalid, rd_empty, rd_busy;
  logic [PW-1:0] wr_level, rd_level;
  logic [DW-1:0] rd_data;
  logic          l2_full, l2_wbusy, l2_dvalid, l2_empty, l2_rbusy;
  logic [PW-1:0] l2_wlevel, l2_rlevel;
  logic [DW-1:0] l2_data;

  int errors = 0;
  int checks = 0;
  int wn, rn, n;
  logic [DW-1:0] model [64];
  int head = 0, tail = 0;

  always #10 wr_clk = ~wr_clk;  // 50 MHz
  always #7  rd_clk = ~rd_clk;

  xfifo_dc #(.DW(DW), .AW(AW), .BUSY_CYC(BUSY_CYC), .SYNC_STAGES(SYNC_STAGES),
             .RD_LAT(xfifo_pkg::RD_LAT1)) dut_i (
    .arst_n(arst_n), .wr_clk(wr_clk), .wr_push(wr_push), .wr_data(wr_data),
    .wr_full(wr_full), .wr_busy(wr_busy), .wr_level(wr_level),
    .rd_clk(rd_clk), .rd_pop(rd_pop), .rd_data(rd_data), .rd_dvalid(rd_dvalid),
    .rd_empty(rd_empty), .rd_busy(rd_busy), .rd_level(rd_level));

  xfifo_dc #(.DW(DW), .AW(AW), .BUSY_CYC(BUSY_CYC), .SYNC_STAGES(SYNC_STAGES),
             .RD_LAT(xfifo_pkg::RD_LAT2)) dut_l2_i (
    .arst_n(arst_n), .wr_clk(wr_clk), .wr_push(wr_push), .wr_data(wr_data),
    .wr_full(l2_full), .wr_busy(l2_wbusy), .wr_level(l2_wlevel),
    .rd_clk(rd_clk), .rd_pop(rd_pop), .rd_data(l2_data), .rd_dvalid(l2_dvalid),
    .rd_empty(l2_empty), .rd_busy(l2_rbusy), .rd_level(l2_rlevel));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wr_clk); wr_push = 1'b1; wr_data = d;
    @(negedge wr_clk); wr_push = 1'b0;
  endtask

  task automatic pop_chk(input logic [DW-1:0] exp, input string req);
    @(negedge rd_clk); rd_pop = 1'b1;
    @(negedge rd_clk); rd_pop = 1'b0;
    chk(rd_dvalid == 1'b1, "R7 lat1 strobe", rd_dvalid, 1);
    chk(rd_data == exp, req, rd_data, exp);
    chk(l2_dvalid == 1'b0, "R7 lat2 early", l2_dvalid, 0);
    @(negedge rd_clk);
    chk(l2_dvalid == 1'b1, "R7 lat2 strobe", l2_dvalid, 1);
    chk(l2_data == exp, req, l2_data, exp);
    chk(rd_dvalid == 1'b0, "R7 lat1 one cycle", rd_dvalid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // reset state
    #50;
    chk(wr_busy && wr_full, "R1 reset", {wr_busy, wr_full}, 3);
    chk(rd_busy && rd_empty, "R2 reset", {rd_busy, rd_empty}, 3);
    chk(wr_level == 0 && rd_level == 0, "R11 reset levels", {wr_level, rd_level}, 0);
    chk(rd_dvalid == 0, "R2 reset strobe", rd_dvalid, 0);

    // release and count guard edges while both sides try to access
    wr_push = 1'b1; wr_data = 8'hDD; rd_pop = 1'b1;
    #51.5 arst_n = 1'b1;
    fork
      begin
        wn = 0;
        while (1) begin
          @(posedge wr_clk); #1; wn++;
          if (!wr_busy || wn > 100) break;
          if (!wr_full) chk(0, "R1 full while busy", wr_full, 1);
        end
        wr_push = 1'b0;
        chk(wn == BUSY_CYC + 2, "R1 busy edges", wn, BUSY_CYC + 2);
      end
      begin
        rn = 0;
        while (1) begin
          @(posedge rd_clk); #1; rn++;
          if (!rd_busy || rn > 100) break;
          if (!rd_empty) chk(0, "R2 empty while busy", rd_empty, 1);
        end
        rd_pop = 1'b0;
        chk(rn == BUSY_CYC + 2, "R2 busy edges", rn, BUSY_CYC + 2);
      end
    join
    repeat (8) @(negedge wr_clk);
    chk(wr_level == 0, "R3 push while busy dropped", wr_level, 0);
    chk(rd_level == 0 && rd_empty, "R2 pop while busy", {rd_level, rd_empty}, 1);
    chk(rd_dvalid == 0 && !wr_busy && !rd_busy, "R2 quiet", rd_dvalid, 0);

    // R6: cross-domain arrival timing, R4: immediate write level
    @(negedge wr_clk); wr_push = 1'b1; wr_data = 8'hA5;
    @(posedge wr_clk); #1; wr_push = 1'b0;
    chk(wr_level == 1, "R4 one write", wr_level, 1);
    n = 0;
    while (1) begin
      @(posedge rd_clk); #1; n++;
      if (!rd_empty || n > 10) break;
    end
    chk(n == SYNC_STAGES, "R6 empty fall edge", n, SYNC_STAGES);
    chk(rd_level == 1, "R6 read level", rd_level, 1);
    push(8'h5A);
    chk(wr_level == 2, "R4 two writes", wr_level, 2);
    repeat (8) @(negedge rd_clk);
    pop_chk(8'hA5, "R8 first out");
    repeat (8) @(negedge wr_clk);
    chk(wr_level == 1, "R9 write level", wr_level, 1);
    chk(rd_level == 1, "R9 read level", rd_level, 1);
    pop_chk(8'h5A, "R8 second out");
    repeat (8) @(negedge wr_clk);
    chk(wr_level == 0 && rd_empty, "R9 drained", wr_level, 0);

    // table walk: pushes with expected write level
    for (int i = 0; i < 8; i++) begin
      push(VEC[i][15:8]);
      model[tail] = VEC[i][15:8]; tail++;
      chk(wr_level == PW'(VEC[i][7:0]), "R4 table level", wr_level, VEC[i][7:0]);
    end
    for (int i = 8; i < DEPTH; i++) begin
      push(DW'(8'h80 + i));
      model[tail] = DW'(8'h80 + i); tail++;
      if (i == DEPTH - 2) chk(!wr_full, "R5 one short of full", wr_full, 0);
    end
    chk(wr_full == 1'b1, "R5 full", wr_full, 1);
    push(8'hEE);
    chk(wr_level == PW'(DEPTH), "R3 push while full", wr_level, DEPTH);
    repeat (8) @(negedge rd_clk);
    chk(rd_level == PW'(DEPTH), "R5 read level full", rd_level, DEPTH);
    while (head < tail) begin
      pop_chk(model[head], "R8 order");
      head++;
    end

    // R10: pop on empty
    repeat (8) @(negedge rd_clk);
    @(negedge rd_clk); rd_pop = 1'b1;
    @(negedge rd_clk); rd_pop = 1'b0;
    chk(rd_dvalid == 0, "R10 no strobe lat1", rd_dvalid, 0);
    @(negedge rd_clk);
    chk(l2_dvalid == 0, "R10 no strobe lat2", l2_dvalid, 0);
    chk(rd_level == 0 && rd_empty, "R10 level", rd_level, 0);
    push(8'h3C);
    repeat (8) @(negedge rd_clk);
    pop_chk(8'h3C, "R10 next word intact");

    // R11: asynchronous reset mid-operation
    push(8'h01); push(8'h02); push(8'h03);
    @(negedge wr_clk); #2.5 arst_n = 1'b0;
    #1;
    chk(wr_busy && rd_busy, "R11 busy immediate", {wr_busy, rd_busy}, 3);
    chk(wr_full && rd_empty, "R11 flags immediate", {wr_full, rd_empty}, 3);
    chk(wr_level == 0 && rd_level == 0, "R11 levels cleared", {wr_level, rd_level}, 0);
    #50;
    @(posedge rd_clk); #2.5 arst_n = 1'b1;
    n = 0;
    while ((wr_busy || rd_busy) && n < 200) begin
      @(negedge wr_clk); n++;
    end
    chk(!wr_busy && !rd_busy, "R11 guard releases", {wr_busy, rd_busy}, 0);
    chk(wr_level == 0 && rd_level == 0 && rd_empty, "R11 contents dropped", {wr_level, rd_level}, 0);
    push(8'h77);
    repeat (8) @(negedge rd_clk);
    pop_chk(8'h77, "R11 usable after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule